// File: doc/BRIEF.md
# Single-Cycle Load-Store RISC Core

This block is a 32-bit processor that completes one instruction per clock for a small load-store subset. In each cycle the instruction word at the program counter arrives from an instruction port. The core decodes it, reads two operands from a 32-entry register file and forms either an ALU result, a data address or a branch decision. It then writes the result back and selects the next program counter. Instruction fetch and data access use separate ports, so a load or store happens in the same cycle as its fetch. Both memories sit outside the block and are expected to answer combinationally.

The supported operations are word load and store, add-immediate, register add, shift-left-by-constant, the absolute jump and jump-and-link, the register jump and register jump-and-link, and three conditional branches. Any other encoding runs as a no-op: it only advances the program counter and raises a sticky flag.

Top module: `rcore_top`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0x00000000 and `illegal` clears. Both take effect on the next edge, and no data store is issued while reset is high.
- R2: `imem_addr` always shows the current program counter. Every instruction that is not a taken branch or jump moves it forward by 4.
- R3: The instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0], immediate [15:0] and target [25:0]. For LW (opcode 0x23) and SW (opcode 0x2B), `dmem_addr` is rs plus the sign-extended immediate. LW writes `dmem_rdata` into rt. SW drives rt on `dmem_wdata` with `dmem_we` high. `dmem_we` is high only for SW.
- R4: ADDIU (opcode 0x09) writes rs plus the sign-extended immediate into rt.
- R5: With opcode 0x00, funct 0x21 (add) writes rs+rt into rd, and funct 0x00 (shift) writes rt shifted left by shamt into rd.
- R6: Register 0 always reads as zero. A write aimed at it has no effect.
- R7: J (0x02) and JAL (0x03) jump to {(PC+4)[31:28], target, 2'b00}. JAL also writes PC+4 into register 31.
- R8: With opcode 0x00, funct 0x08 (JR) jumps to the value of rs. Funct 0x09 (JALR) does the same and writes PC+4 into rd.
- R9: BEQ (0x04) branches when rs equals rt. BNE (0x05) branches when they differ. BLEZ (0x06) branches when rs, read as signed, is at most zero. A taken branch goes to PC+4 plus the sign-extended immediate times 4. No branch writes a register, and neither does a store.
- R10: Any other opcode, or any other funct under opcode 0x00, writes nothing and advances the PC by 4. It also sets `illegal`, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, taken at the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |
| illegal | output | 1 | Sticky unrecognised-instruction flag |

## Verification
The bound checker watches several properties on every cycle. The PC must return to zero after reset and move forward by exactly 4 after loads, stores and add-immediates. The absolute jump target must be built correctly, the store strobe must appear only for a store opcode, and the illegal flag must rise on unknown opcodes and then stay set. Register contents are not visible at the ports, so the arithmetic results, link values, load data and the discarded writes to register 0 are shown only by the bench's program. That program stores each of these values to memory and compares them with a behavioural model. The same program and model cover branch decisions in both directions, backward offsets and recovery after a mid-run reset.

// File: rtl/rcore_pkg.sv
package rcore_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;

  localparam logic [5:0] OPC_SPECIAL = 6'h00;
  localparam logic [5:0] OPC_J       = 6'h02;
  localparam logic [5:0] OPC_JAL     = 6'h03;
  localparam logic [5:0] OPC_BEQ     = 6'h04;
  localparam logic [5:0] OPC_BNE     = 6'h05;
  localparam logic [5:0] OPC_BLEZ    = 6'h06;
  localparam logic [5:0] OPC_ADDIU   = 6'h09;
  localparam logic [5:0] OPC_LW      = 6'h23;
  localparam logic [5:0] OPC_SW      = 6'h2B;

  localparam logic [5:0] FUN_SLL  = 6'h00;
  localparam logic [5:0] FUN_JR   = 6'h08;
  localparam logic [5:0] FUN_JALR = 6'h09;
  localparam logic [5:0] FUN_ADDU = 6'h21;

  typedef enum logic [1:0] {RES_SUM, RES_SHIFT, RES_LINK} res_sel_e;
  typedef enum logic [2:0] {NXT_SEQ, NXT_EQ, NXT_NE, NXT_LEZ, NXT_ABS, NXT_REG} nxt_sel_e;

  typedef struct packed {
    logic [RIDX_W-1:0] src_a;
    logic [RIDX_W-1:0] src_b;
    logic [RIDX_W-1:0] dst;
    logic [4:0]        shamt;
    logic [25:0]       target;
    logic [XLEN-1:0]   imm;
    logic              use_imm;
    logic              wr_en;
    logic              ld;
    logic              st;
    logic              bad;
    res_sel_e          res_sel;
    nxt_sel_e          nxt_sel;
  } ctl_t;
endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
  import rcore_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctl_t            ctl
);
  logic [5:0] opc;
  logic [5:0] fun;

  assign opc = instr[31:26];
  assign fun = instr[5:0];

  always_comb begin
    ctl         = '0;
    ctl.src_a   = instr[25:21];
    ctl.src_b   = instr[20:16];
    ctl.dst     = instr[20:16];
    ctl.shamt   = instr[10:6];
    ctl.target  = instr[25:0];
    ctl.imm     = {{(XLEN-16){instr[15]}}, instr[15:0]};
    ctl.res_sel = RES_SUM;
    ctl.nxt_sel = NXT_SEQ;
    unique case (opc)
      OPC_SPECIAL: begin
        ctl.dst = instr[15:11];
        unique case (fun)
          FUN_ADDU: ctl.wr_en = 1'b1;
          FUN_SLL: begin
            ctl.wr_en   = 1'b1;
            ctl.res_sel = RES_SHIFT;
          end
          FUN_JR:   ctl.nxt_sel = NXT_REG;
          FUN_JALR: begin
            ctl.nxt_sel = NXT_REG;
            ctl.res_sel = RES_LINK;
            ctl.wr_en   = 1'b1;
          end
          default:  ctl.bad = 1'b1;
        endcase
      end
      OPC_ADDIU: begin
        ctl.use_imm = 1'b1;
        ctl.wr_en   = 1'b1;
      end
      OPC_LW: begin
        ctl.use_imm = 1'b1;
        ctl.ld      = 1'b1;
        ctl.wr_en   = 1'b1;
      end
      OPC_SW: begin
        ctl.use_imm = 1'b1;
        ctl.st      = 1'b1;
      end
      OPC_BEQ:  ctl.nxt_sel = NXT_EQ;
      OPC_BNE:  ctl.nxt_sel = NXT_NE;
      OPC_BLEZ: ctl.nxt_sel = NXT_LEZ;
      OPC_J:    ctl.nxt_sel = NXT_ABS;
      OPC_JAL: begin
        ctl.nxt_sel = NXT_ABS;
        ctl.res_sel = RES_LINK;
        ctl.wr_en   = 1'b1;
        ctl.dst     = 5'd31;
      end
      default: ctl.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] bank [NREGS];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) bank[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : bank[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : bank[raddr_b];
endmodule

// File: rtl/rcore_exec.sv
module rcore_exec
  import rcore_pkg::*;
(
  input  ctl_t            ctl,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] sum,
  output logic [XLEN-1:0] result,
  output logic [XLEN-1:0] next_pc
);
  logic [XLEN-1:0] pc_inc;
  logic [XLEN-1:0] br_dest;
  logic            take;

  assign pc_inc  = pc + XLEN'(4);
  assign br_dest = pc_inc + {ctl.imm[XLEN-3:0], 2'b00};
  assign sum     = opa + (ctl.use_imm ? ctl.imm : opb);

  always_comb begin
    unique case (ctl.res_sel)
      RES_SHIFT: result = opb << ctl.shamt;
      RES_LINK:  result = pc_inc;
      default:   result = sum;
    endcase
  end

  always_comb begin
    unique case (ctl.nxt_sel)
      NXT_EQ:  take = (opa == opb);
      NXT_NE:  take = (opa != opb);
      NXT_LEZ: take = ($signed(opa) <= 0);
      default: take = 1'b0;
    endcase
  end

  always_comb begin
    unique case (ctl.nxt_sel)
      NXT_ABS: next_pc = {pc_inc[XLEN-1:28], ctl.target, 2'b00};
      NXT_REG: next_pc = opa;
      NXT_EQ, NXT_NE, NXT_LEZ: next_pc = take ? br_dest : pc_inc;
      default: next_pc = pc_inc;
    endcase
  end
endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter int          NREGS    = 32,
  localparam int         AW       = $clog2(NREGS)
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic        illegal
);
  logic [XLEN-1:0] pc_q;
  logic            bad_q;
  ctl_t            ctl;
  logic [XLEN-1:0] val_a, val_b, sum, result, next_pc, wb_data;

  rcore_decode u_dec (.instr(imem_rdata), .ctl(ctl));

  rcore_regfile #(.NREGS(NREGS), .WIDTH(XLEN)) u_rf (
    .clk     (clk),
    .we      (ctl.wr_en & ~rst),
    .waddr   (ctl.dst[AW-1:0]),
    .wdata   (wb_data),
    .raddr_a (ctl.src_a[AW-1:0]),
    .raddr_b (ctl.src_b[AW-1:0]),
    .rdata_a (val_a),
    .rdata_b (val_b)
  );

  rcore_exec u_ex (
    .ctl     (ctl),
    .pc      (pc_q),
    .opa     (val_a),
    .opb     (val_b),
    .sum     (sum),
    .result  (result),
    .next_pc (next_pc)
  );

  assign wb_data = ctl.ld ? dmem_rdata : result;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_PC;
      bad_q <= 1'b0;
    end else begin
      pc_q <= next_pc;
      if (ctl.bad) bad_q <= 1'b1;
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = sum;
  assign dmem_wdata = val_b;
  assign dmem_we    = ctl.st & ~rst;
  assign illegal    = bad_q;
endmodule

// File: rtl/rcore_checker.sv
module rcore_checker #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic        dmem_we,
  input logic        illegal
);
  logic [5:0]  op;
  logic [31:0] jdest;
  logic        known;

  assign op    = imem_rdata[31:26];
  assign jdest = {imem_addr[31:28] + {3'b0, &imem_addr[27:2]}, imem_rdata[25:0], 2'b00};
  assign known = (op == 6'h00) || (op == 6'h02) || (op == 6'h03) || (op == 6'h04) ||
                 (op == 6'h05) || (op == 6'h06) || (op == 6'h09) || (op == 6'h23) ||
                 (op == 6'h2B);

  AST_RESET_PC: assert property (@(posedge clk) rst |=> (imem_addr == RESET_PC)); // R1
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    ((op == 6'h23) || (op == 6'h2B) || (op == 6'h09)) |=> (imem_addr == $past(imem_addr) + 32'd4)); // R2
  AST_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (op == 6'h2B)); // R3
  AST_JUMP_DEST: assert property (@(posedge clk) disable iff (rst)
    ((op == 6'h02) || (op == 6'h03)) |=> (imem_addr == $past(jdest))); // R7
  AST_BAD_RAISE: assert property (@(posedge clk) disable iff (rst)
    !known |=> illegal); // R10
  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (rst)
    illegal |=> illegal); // R10
endmodule

bind rcore_top rcore_checker #(.RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
  .dmem_we(dmem_we), .illegal(illegal)
);

// File: tb/rcore_top_test.sv
`timescale 1ns/1ps
module rcore_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, illegal;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] prog [64];
  logic [31:0] dram [64];

  logic [31:0] m_regs [32];
  logic [31:0] m_dram [64];
  logic [31:0] m_pc;
  logic        m_bad;
  string       pc_tag;

  always #2.5 clk = ~clk;

  rcore_top uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .illegal(illegal)
  );

  assign imem_rdata = prog[imem_addr[7:2]];
  assign dmem_rdata = dram[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dram[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] ei(logic [5:0] op, int rs, int rt, int imm);
    logic [31:0] iv = imm;
    logic [31:0] sv = rs;
    logic [31:0] tv = rt;
    return {op, sv[4:0], tv[4:0], iv[15:0]};
  endfunction

  function automatic logic [31:0] er(int rs, int rt, int rd, int sh, logic [5:0] fn);
    logic [31:0] sv = rs;
    logic [31:0] tv = rt;
    logic [31:0] dv = rd;
    logic [31:0] hv = sh;
    return {6'h00, sv[4:0], tv[4:0], dv[4:0], hv[4:0], fn};
  endfunction

  function automatic logic [31:0] ej(logic [5:0] op, int word);
    logic [31:0] wv = word;
    return {op, wv[25:0]};
  endfunction

  function automatic string tag_of_store(logic [31:0] a);
    case (a)
      32'h40: return "R5";
      32'h44: return "R5";
      32'h48: return "R6";
      32'h4C: return "R3";
      32'h50: return "R7";
      32'h54: return "R8";
      32'h58: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] idx, logic [31:0] v);
    if (idx != 5'd0) m_regs[idx] = v;
  endtask

  task automatic compare_and_step();
    logic [31:0] ins, a, b, se, p4, ea;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, sh;
    check(imem_addr == m_pc, pc_tag, imem_addr, m_pc);
    check(illegal == m_bad, "R10", {31'd0, illegal}, {31'd0, m_bad});
    ins = prog[m_pc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; sh = ins[10:6];
    a = m_regs[rs]; b = m_regs[rt];
    se = {{16{ins[15]}}, ins[15:0]};
    p4 = m_pc + 32'd4;
    ea = a + se;
    check(dmem_we == (op == 6'h2B), "R3", {31'd0, dmem_we}, {31'd0, op == 6'h2B});
    pc_tag = "R2";
    m_pc = p4;
    case (op)
      6'h00: case (fn)
        6'h21: wr(rd, a + b);
        6'h00: wr(rd, b << sh);
        6'h08: begin m_pc = a; pc_tag = "R8"; end
        6'h09: begin m_pc = a; pc_tag = "R8"; wr(rd, p4); end
        default: begin m_bad = 1'b1; pc_tag = "R10"; end
      endcase
      6'h09: wr(rt, ea);
      6'h23: begin
        check(dmem_addr == ea, "R3", dmem_addr, ea);
        wr(rt, m_dram[ea[7:2]]);
      end
      6'h2B: begin
        check(dmem_addr == ea, "R3", dmem_addr, ea);
        check(dmem_wdata == b, tag_of_store(ea), dmem_wdata, b);
        m_dram[ea[7:2]] = b;
      end
      6'h04, 6'h05, 6'h06: begin
        pc_tag = "R9";
        if ((op == 6'h04 && a == b) || (op == 6'h05 && a != b) ||
            (op == 6'h06 && $signed(a) <= 0))
          m_pc = p4 + {se[29:0], 2'b00};
      end
      6'h02, 6'h03: begin
        pc_tag = "R7";
        m_pc = {p4[31:28], ins[25:0], 2'b00};
        if (op == 6'h03) wr(5'd31, p4);
      end
      default: begin m_bad = 1'b1; pc_tag = "R10"; end
    endcase
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #10000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      prog[i] = 32'h0; dram[i] = 32'h0; m_dram[i] = 32'h0;
    end
    for (int i = 0; i < 32; i++) m_regs[i] = 32'h0;
    prog[0]  = ei(6'h09, 0, 1, 5);            // ADDIU r1 = 5 (R4)
    prog[1]  = ei(6'h09, 0, 2, -3);           // ADDIU r2 = -3 (R4)
    prog[2]  = er(1, 2, 3, 0, 6'h21);         // ADDU r3 = 2 (R5)
    prog[3]  = er(0, 1, 4, 4, 6'h00);         // SLL r4 = 80 (R5)
    prog[4]  = ei(6'h2B, 0, 3, 32'h40);
    prog[5]  = ei(6'h2B, 0, 4, 32'h44);
    prog[6]  = ei(6'h09, 0, 0, 7);            // write to r0 dropped (R6)
    prog[7]  = ei(6'h2B, 0, 0, 32'h48);
    prog[8]  = ei(6'h23, 0, 5, 32'h40);       // LW r5 (R3)
    prog[9]  = ei(6'h2B, 0, 5, 32'h4C);
    prog[10] = ei(6'h04, 1, 2, 5);            // BEQ not taken (R9)
    prog[11] = ei(6'h05, 1, 2, 1);            // BNE taken (R9)
    prog[12] = ei(6'h09, 0, 6, 99);
    prog[13] = ei(6'h06, 2, 0, 1);            // BLEZ taken, negative (R9)
    prog[14] = ei(6'h09, 0, 6, 99);
    prog[15] = ei(6'h06, 1, 0, 5);            // BLEZ not taken (R9)
    prog[16] = ej(6'h03, 20);                 // JAL (R7)
    prog[17] = ei(6'h2B, 0, 31, 32'h50);
    prog[18] = ej(6'h02, 24);                 // J (R7)
    prog[20] = er(31, 0, 0, 0, 6'h08);        // JR (R8)
    prog[24] = ei(6'h09, 0, 9, 32'h70);
    prog[25] = er(9, 0, 10, 0, 6'h09);        // JALR (R8)
    prog[28] = ei(6'h2B, 0, 10, 32'h54);
    prog[29] = 32'hFC00_0000;                 // unknown opcode (R10)
    prog[30] = ei(6'h2B, 0, 1, 32'h58);
    prog[31] = er(0, 0, 0, 0, 6'h3F);         // unknown funct (R10)
    prog[32] = ei(6'h04, 1, 1, -1);           // BEQ taken, backward (R9)

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    m_pc = 32'h0; m_bad = 1'b0; pc_tag = "R1";
    @(negedge clk);
    check(imem_addr == 32'h0, "R1", imem_addr, 32'h0);
    check(illegal == 1'b0, "R1", {31'd0, illegal}, 32'h0);
    compare_and_step();
    repeat (50) begin
      @(negedge clk);
      compare_and_step();
    end

    @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    m_pc = 32'h0; m_bad = 1'b0; pc_tag = "R1";
    @(negedge clk);
    check(imem_addr == 32'h0, "R1", imem_addr, 32'h0);
    check(illegal == 1'b0, "R1", {31'd0, illegal}, 32'h0);
    repeat (50) begin
      compare_and_step();
      @(negedge clk);
    end
    finish_run();
  end
endmodule